// File: doc/BRIEF.md
# Six-Line UART Interrupt Controller

This block gathers the interrupt events of a UART datapath into one status word. It lets software choose which of them may reach the processor, and it drives six level interrupt lines: one summary line and five lines, one per event group. The datapath reports each event as a one-cycle pulse on its own input bit, and a write to the transmit data register arrives on its own pulse input. Software sees four word registers through a simple write-strobe, combinational-read register port:

| Offset | Register | Access |
|--------|----------|--------|
| 0 | enable | read/write |
| 1 | pending | read only |
| 2 | active (pending AND enable) | read only |
| 3 | acknowledge | write-one-to-clear, reads 0 |

Every interrupt line is a flop. Each line is the OR, over its group, of the pending bits that are enabled. A raw event or a software write therefore reaches the pins one clock after the status or enable register itself changes. There is no sequencing in the block, so it has no state machine. Its only state is the 11-bit pending register, the 11-bit enable register and the six output flops.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the enable and pending registers read 0 and all six interrupt lines are low.
- R2: A 1 on bit i of `src_set` sets pending bit i at the next clock. The bit then stays set until it is acknowledged. The bit layout is: bits 0 to 3 modem sources (RI, CTS, DCD, DSR), bit 4 receive, bit 5 transmit, bit 6 receive timeout, bits 7 to 10 framing, parity, break and overrun errors.
- R3: A pulse on `tx_data_wr` sets pending bit 5 whatever the enable register holds.
- R4: A write to offset 0 replaces the whole enable register with write data bits 10:0. A read of offset 0 returns that value, with bits 31:11 read as 0.
- R5: A read of offset 1 returns the pending bits. A read of offset 2 returns the pending bits ANDed with the enable bits.
- R6: A write to offset 3 clears every pending bit whose write data bit is 1 and leaves the other pending bits unchanged. A read of offset 3 returns 0.
- R7: A write to offset 1, offset 2 or any offset above 3 changes no register. A read of an offset above 3 returns 0.
- R8: If a set pulse and an acknowledge of the same pending bit occur in the same cycle, the bit ends up set.
- R9: Line 0 is the OR of all active bits. Lines 1 to 5 are the OR of the active bits of, in order, the receive (bit 4), transmit (bit 5), receive-timeout (bit 6), modem (bits 3:0) and error (bits 10:7) groups.
- R10: The lines are registered. They reflect the pending and enable values held in the cycle before, so a set pulse sampled at edge k changes a line at edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| src_set | input | 11 | One-cycle set pulses from the datapath, one per pending bit |
| tx_data_wr | input | 1 | Pulse: transmit data register was written |
| irq_out | output | 6 | Bit 0 summary line, bits 1 to 5 group lines |

## Verification
A behavioural model in the bench predicts the register reads and all six lines, and every cycle is compared against it.

Directed patterns cover the following:
- Each single source is raised with every bit enabled. This separates the grouping of each line and shows that no bit leaks into a neighbour group.
- Transmit data writes are made with the enable register at zero. This shows that the pending bit is set regardless of the enable register while the lines stay low.
- Writes go to the read-only and unmapped offsets. This shows that they change nothing.
- A set pulse and an acknowledge of the same bit are given together. This separates set-priority from clear-priority.

A pseudo-random stretch then mixes events, enable rewrites and partial acknowledges. It catches the timing of the one-cycle output lag against the timing of the registers.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC = 11;
    localparam int NGRP = 5;
    localparam int NOUT = NGRP + 1;

    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;
    localparam int BIT_RT = 6;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_PEND   = 2'd1,
        REG_ACTIVE = 2'd2,
        REG_ACK    = 2'd3
    } reg_sel_e;

    // Members of group line g+1.
    function automatic src_vec_t grp_members(input int g);
        src_vec_t m;
        m = '0;
        unique case (g)
            0: m[BIT_RX] = 1'b1;
            1: m[BIT_TX] = 1'b1;
            2: m[BIT_RT] = 1'b1;
            3: m[3:0]    = 4'hF;
            default: m[10:7] = 4'hF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_vec,
    input  src_vec_t clr_vec,
    output src_vec_t pend
);

    src_vec_t pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            // a set pulse outranks an acknowledge of the same bit
            pend_q <= (pend_q & ~clr_vec) | set_vec;
        end
    end

    assign pend = pend_q;

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && clr_vec == '0) |=> $stable(pend_q));

endmodule

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  src_vec_t wr_data,
    output src_vec_t en
);

    src_vec_t en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_data;
        end
    end

    assign en = en_q;

    p_enable_replace_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wr_data)));

    p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  src_vec_t        pend,
    input  src_vec_t        en,
    output logic [NOUT-1:0] irq
);

    src_vec_t        active;
    logic [NOUT-1:0] irq_q;

    assign active = pend & en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q[0] <= 1'b0;
        end else begin
            irq_q[0] <= |active;
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_group
        localparam src_vec_t MEMBERS = grp_members(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_q[g+1] <= 1'b0;
            end else begin
                irq_q[g+1] <= |(active & MEMBERS);
            end
        end
    end

    assign irq = irq_q;

    p_summary_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[0] == (|irq_q[NOUT-1:1]));

    p_one_cycle_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q[0] == (|($past(pend) & $past(en)))));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   src_set,
    input  logic              tx_data_wr,
    output logic [NOUT-1:0]   irq_out
);

    localparam logic [ADDR_W-1:0] OFS_ENABLE = ADDR_W'(REG_ENABLE);
    localparam logic [ADDR_W-1:0] OFS_PEND   = ADDR_W'(REG_PEND);
    localparam logic [ADDR_W-1:0] OFS_ACTIVE = ADDR_W'(REG_ACTIVE);
    localparam logic [ADDR_W-1:0] OFS_ACK    = ADDR_W'(REG_ACK);

    src_vec_t wr_bits;
    src_vec_t set_vec;
    src_vec_t clr_vec;
    src_vec_t pend;
    src_vec_t en;
    logic     en_wr;
    logic     unused_wdata;

    assign wr_bits      = reg_wdata[NSRC-1:0];
    assign unused_wdata = &{1'b0, reg_wdata[DATA_W-1:NSRC]};

    always_comb begin
        set_vec         = src_set;
        set_vec[BIT_TX] = src_set[BIT_TX] | tx_data_wr;
    end

    assign en_wr   = reg_wr_en && (reg_addr == OFS_ENABLE);
    assign clr_vec = (reg_wr_en && (reg_addr == OFS_ACK)) ? wr_bits : '0;

    uart_irq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    uart_irq_enable u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (en_wr),
        .wr_data (wr_bits),
        .en      (en)
    );

    uart_irq_lines u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .en    (en),
        .irq   (irq_out)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_ENABLE: reg_rdata[NSRC-1:0] = en;
            OFS_PEND:   reg_rdata[NSRC-1:0] = pend;
            OFS_ACTIVE: reg_rdata[NSRC-1:0] = pend & en;
            default:    reg_rdata = '0;
        endcase
    end

    p_ro_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr != OFS_ENABLE && reg_addr != OFS_ACK
         && src_set == '0 && !tx_data_wr) |=> ($stable(pend) && $stable(en)));

    p_tx_write_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_data_wr |=> pend[BIT_TX]);

endmodule

// File: tb/uart_irq_ctrl_bench.sv
`timescale 1ns/1ps
module uart_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] src_set = '0;
    logic        tx_data_wr = 1'b0;
    logic [5:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int unsigned m_pend = 0;
    int unsigned m_en = 0;
    logic [5:0]  m_irq = '0;
    int unsigned lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .src_set    (src_set),
        .tx_data_wr (tx_data_wr),
        .irq_out    (irq_out)
    );

    function automatic logic [5:0] lines_of(int unsigned p, int unsigned e);
        logic [10:0] a;
        logic [5:0]  r;
        a    = 11'(p & e);
        r[0] = |a;
        r[1] = a[4];
        r[2] = a[5];
        r[3] = a[6];
        r[4] = |a[3:0];
        r[5] = |a[10:7];
        return r;
    endfunction

    function automatic int unsigned read_of(int addr);
        if (addr == 0) return m_en;
        if (addr == 1) return m_pend;
        if (addr == 2) return m_pend & m_en;
        return 0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit wr, input int addr,
                        input int unsigned wdata, input int unsigned evt, input bit txw);
        int unsigned clr;
        @(negedge clk);
        check("R9_R10 lines", 32'(irq_out), 32'(m_irq));
        reg_wr_en  = wr;
        reg_addr   = 4'(addr);
        reg_wdata  = wdata;
        src_set    = 11'(evt);
        tx_data_wr = txw;
        #1;
        check(tag, reg_rdata, read_of(addr));
        @(posedge clk);
        m_irq = lines_of(m_pend, m_en);
        clr = (wr && addr == 3) ? (wdata & 32'h7FF) : 0;
        m_pend = (m_pend & ~clr) | (evt & 32'h7FF) | (txw ? 32'h20 : 0);
        if (wr && addr == 0) m_en = wdata & 32'h7FF;
    endtask

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 lines in reset", 32'(irq_out), 0);
        for (int a = 0; a < 3; a++) begin
            reg_addr = 4'(a);
            #1;
            check("R1 register in reset", reg_rdata, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 0, 1, 0, 0, 0);

        // R4: enable all, upper write bits dropped
        step("R4", 1, 0, 32'hFFFF_FFFF, 0, 0);
        step("R4", 0, 0, 0, 0, 0);

        // R2 / R9: each source alone, then acknowledged
        for (int i = 0; i < 11; i++) begin
            step("R2", 0, 1, 0, 32'(1) << i, 0);
            step("R2", 0, 1, 0, 0, 0);
            step("R9", 0, 2, 0, 0, 0);
            step("R6", 1, 3, 32'(1) << i, 0, 0);
            step("R6", 0, 1, 0, 0, 0);
        end

        // R3: transmit write with nothing enabled
        step("R3", 1, 0, 0, 0, 0);
        step("R3", 0, 1, 0, 0, 1);
        step("R3", 0, 1, 0, 0, 0);
        step("R3", 0, 2, 0, 0, 0);

        // R7: writes to read-only and unmapped offsets
        step("R7", 1, 1, 32'hFFFF_FFFF, 0, 0);
        step("R7", 1, 2, 32'h0, 0, 0);
        step("R7", 1, 9, 32'hFFFF_FFFF, 0, 0);
        step("R7", 0, 1, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0);
        step("R7", 0, 12, 0, 0, 0);

        // R8: set and acknowledge together
        step("R8", 1, 0, 32'h7FF, 0, 0);
        step("R8", 1, 3, 32'h7FF, 32'h090, 0);
        step("R8", 0, 1, 0, 0, 0);
        step("R8", 1, 3, 32'h020, 0, 1);
        step("R8", 0, 1, 0, 0, 0);

        // R5: partial enable
        step("R5", 1, 0, 32'h0A5, 32'h7FF, 0);
        step("R5", 0, 2, 0, 0, 0);
        step("R5", 1, 3, 32'h00F, 0, 0);
        step("R5", 0, 2, 0, 0, 0);
        step("R6", 0, 3, 0, 0, 0);

        // mixed pseudo-random traffic
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            r = lfsr;
            step("R5", r[0] & r[1], int'(r[5:2]) % 6, r >> 8,
                 (r[6] ? (r >> 19) : 0), r[7] & r[30]);
        end
        step("R5", 0, 2, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule